// File: doc/BRIEF.md
# Slotted PWM Current-Sink Controller

This block produces the on/off enables for three current sinks that drive LEDs or a vibration motor. Each channel holds a 6-bit duty code and a 4-bit current-limit code. The duty code does not feed a ramp compare. It picks how many slots of a 63-slot frame the sink is on. The frame has nine major cycles, and each major cycle has seven minor slots. On-slots fill one minor position in every major cycle before they move to the next minor position. This spreads the on-time evenly across the frame, so it is not packed at the start.

A single write port loads both codes for one channel at a time. The current-limit code goes straight out to the analog DAC. The duty code is staged and becomes active only at the next frame boundary. An internal prescaler sets how many clock cycles each slot lasts. A frame marker output is high during slot 0.

Top module: `slot_pwm_top`

## Requirements
- R1: While `rst_ni` is low, and after reset is released, `sink_en_o` and `ilim_o` are zero, all active duty codes are zero, and the frame starts at slot 0 with `frame_o` high.
- R2: Each slot lasts `SLOT_DIV` clock cycles. A frame is 63 slots long, and `frame_o` is high for exactly the `SLOT_DIV` cycles of slot 0. This gives a frame period of 63*`SLOT_DIV` cycles.
- R3: With an active duty code N (0..63), each channel is on in exactly N slots of every frame.
- R4: Slot index s = 7*m + n, where m is the major cycle (0..8) and n is the minor slot (0..6). The slot is on when n*9 + m < N.
- R5: Duty code 0 keeps the sink off for the whole frame.
- R6: Duty code 63 keeps the sink on in all 63 slots.
- R7: A duty code written during a frame does not change that frame. It becomes active from the first cycle of the next slot 0.
- R8: The current-limit code of channel c appears on `ilim_o[4c+3:4c]` in the cycle after the write. A code of 0xF on channel 0 reads back as 0xF.
- R9: A write with `wr_ch_i` = 3 changes neither duty nor current-limit state on any channel.
- R10: A write to one channel leaves the codes of the other channels unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Write strobe for one channel's codes |
| wr_ch_i | input | 2 | Target channel index (0..2) |
| wr_duty_i | input | 6 | Duty code, in slots per frame |
| wr_ilim_i | input | 4 | Current-limit code |
| sink_en_o | output | 3 | Per-channel sink enable |
| ilim_o | output | 12 | Current-limit codes; channel c in bits 4c+3:4c |
| frame_o | output | 1 | High during slot 0 of each frame |

## Verification
A fault in the slot indices or the prescaler changes the frame period or the width of the `frame_o` pulse. It also moves on-slots to positions the rank rule does not predict. Both show up within one frame of 63*`SLOT_DIV` cycles. A duty register that loads at the wrong time, or loads the wrong value, gives an on-slot count that differs from the code in the first frame measured after the write. A sweep of every code on all three channels exposes ranking errors at off-by-one codes such as 9, 54 and 62.

// File: rtl/slot_pwm_pkg.sv
package slot_pwm_pkg;
  localparam int N_CH    = 3;
  localparam int MAJOR_N = 9;
  localparam int MINOR_N = 7;
  localparam int SLOTS   = MAJOR_N * MINOR_N;
  localparam int DUTY_W  = $clog2(SLOTS + 1);
  localparam int ILIM_W  = 4;
  localparam int MAJ_W   = $clog2(MAJOR_N);
  localparam int MIN_W   = $clog2(MINOR_N);
  localparam int CH_W    = $clog2(N_CH + 1);
endpackage

// File: rtl/slot_timer.sv
module slot_timer
  import slot_pwm_pkg::*;
#(
  parameter int SLOT_DIV = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  output logic [MAJ_W-1:0] major_o,
  output logic [MIN_W-1:0] minor_o,
  output logic             wrap_o
);
  localparam int PRE_W = (SLOT_DIV > 1) ? $clog2(SLOT_DIV) : 1;

  logic [PRE_W-1:0] pre_q;
  logic [MAJ_W-1:0] major_q;
  logic [MIN_W-1:0] minor_q;
  logic             tick;
  logic             minor_last, major_last;

  assign tick       = (pre_q == PRE_W'(SLOT_DIV - 1));
  assign minor_last = (minor_q == MIN_W'(MINOR_N - 1));
  assign major_last = (major_q == MAJ_W'(MAJOR_N - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pre_q   <= '0;
      major_q <= '0;
      minor_q <= '0;
    end else begin
      pre_q <= tick ? '0 : pre_q + 1'b1;
      if (tick) begin
        minor_q <= minor_last ? '0 : minor_q + 1'b1;
        if (minor_last) major_q <= major_last ? '0 : major_q + 1'b1;
      end
    end
  end

  assign major_o = major_q;
  assign minor_o = minor_q;
  assign wrap_o  = tick & minor_last & major_last;

  AST_IDX_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (minor_q < MIN_W'(MINOR_N)) && (major_q < MAJ_W'(MAJOR_N))); // R2
  AST_MINOR_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick |=> $stable(minor_q) && $stable(major_q)); // R2
  AST_MINOR_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick && minor_last) |=> (minor_q == '0)); // R2
endmodule

// File: rtl/sink_channel.sv
module sink_channel
  import slot_pwm_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [DUTY_W-1:0] duty_i,
  input  logic [ILIM_W-1:0] ilim_i,
  input  logic              load_i,
  input  logic [MAJ_W-1:0]  major_i,
  input  logic [MIN_W-1:0]  minor_i,
  output logic              en_o,
  output logic [ILIM_W-1:0] ilim_o
);
  logic [DUTY_W-1:0] duty_pend_q, duty_act_q;
  logic [ILIM_W-1:0] ilim_q;
  logic [DUTY_W-1:0] rank;

  // minor position fills across all major cycles first
  assign rank = DUTY_W'(minor_i) * DUTY_W'(MAJOR_N) + DUTY_W'(major_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      duty_pend_q <= '0;
      duty_act_q  <= '0;
      ilim_q      <= '0;
    end else begin
      if (wr_i) begin
        duty_pend_q <= duty_i;
        ilim_q      <= ilim_i;
      end
      if (load_i) duty_act_q <= wr_i ? duty_i : duty_pend_q;
    end
  end

  assign en_o   = (rank < duty_act_q);
  assign ilim_o = ilim_q;

  AST_DUTY_FRAME_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> $stable(duty_act_q)); // R7
  AST_ZERO_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (duty_act_q == '0) |-> !en_o); // R5
  AST_FULL_ON: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (duty_act_q == DUTY_W'(SLOTS)) |-> en_o); // R6
  AST_ILIM_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_i |=> $stable(ilim_q)); // R9
endmodule

// File: rtl/slot_pwm_top.sv
module slot_pwm_top
  import slot_pwm_pkg::*;
#(
  parameter int SLOT_DIV = 4
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     wr_en_i,
  input  logic [CH_W-1:0]          wr_ch_i,
  input  logic [DUTY_W-1:0]        wr_duty_i,
  input  logic [ILIM_W-1:0]        wr_ilim_i,
  output logic [N_CH-1:0]          sink_en_o,
  output logic [N_CH*ILIM_W-1:0]   ilim_o,
  output logic                     frame_o
);
  logic [MAJ_W-1:0] major;
  logic [MIN_W-1:0] minor;
  logic             wrap;

  slot_timer #(.SLOT_DIV(SLOT_DIV)) timer_i (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .major_o (major),
    .minor_o (minor),
    .wrap_o  (wrap)
  );

  for (genvar g = 0; g < N_CH; g++) begin : g_ch
    logic wr_sel;
    assign wr_sel = wr_en_i && (wr_ch_i == CH_W'(g));
    sink_channel ch_i (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .wr_i    (wr_sel),
      .duty_i  (wr_duty_i),
      .ilim_i  (wr_ilim_i),
      .load_i  (wrap),
      .major_i (major),
      .minor_i (minor),
      .en_o    (sink_en_o[g]),
      .ilim_o  (ilim_o[g*ILIM_W +: ILIM_W])
    );
  end

  assign frame_o = (major == '0) && (minor == '0);

  AST_FRAME_AFTER_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wrap |=> frame_o); // R2
  AST_ONEHOT_WR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({g_ch[2].wr_sel, g_ch[1].wr_sel, g_ch[0].wr_sel})); // R10
endmodule

// File: tb/slot_pwm_top_tb_top.sv
module slot_pwm_top_tb_top;
  localparam int DIV = 4;
  localparam int FRAME = 63 * DIV;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_ch = '0;
  logic [5:0]  wr_duty = '0;
  logic [3:0]  wr_ilim = '0;
  logic [2:0]  sink_en;
  logic [11:0] ilim;
  logic        frame;
  int total = 0, bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  slot_pwm_top #(.SLOT_DIV(DIV)) dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .wr_en_i(wr_en), .wr_ch_i(wr_ch),
    .wr_duty_i(wr_duty), .wr_ilim_i(wr_ilim), .sink_en_o(sink_en),
    .ilim_o(ilim), .frame_o(frame)
  );

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic bit exp_on(input int code, input int slot);
    int m, n;
    m = slot / 7;
    n = slot % 7;
    return (n * 9 + m) < code;
  endfunction

  task automatic wr(input int ch, input int duty, input int il);
    @(negedge clk);
    wr_en = 1'b1; wr_ch = 2'(ch); wr_duty = 6'(duty); wr_ilim = 4'(il);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wait_frame();
    @(negedge clk);
    while (frame) @(negedge clk);
    while (!frame) @(negedge clk);
  endtask

  // starts at first cycle of slot 0, ends at first cycle of next slot 0
  task automatic measure(input int e0, input int e1, input int e2, input string req);
    int exp_c[3];
    int cnt[3];
    int perr[3];
    exp_c[0] = e0; exp_c[1] = e1; exp_c[2] = e2;
    for (int c = 0; c < 3; c++) begin cnt[c] = 0; perr[c] = 0; end
    for (int i = 0; i < FRAME; i++) begin
      for (int c = 0; c < 3; c++) begin
        if (sink_en[c]) cnt[c]++;
        if (sink_en[c] != exp_on(exp_c[c], i / DIV)) perr[c]++;
      end
      @(negedge clk);
    end
    for (int c = 0; c < 3; c++) begin
      check({req, " R3 count"}, cnt[c] / DIV, exp_c[c]);
      check({req, " R4 pattern"}, perr[c], 0);
    end
  endtask

  task automatic t_reset();
    rst_ni = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 en in reset", int'(sink_en), 0);
    check("R1 ilim in reset", int'(ilim), 0);
    rst_ni = 1'b1;
    @(negedge clk);
    check("R1 frame after reset", int'(frame), 1);
    check("R1 en after reset", int'(sink_en), 0);
  endtask

  task automatic t_period();
    int hi, len;
    wait_frame();
    hi = 0; len = 0;
    while (frame) begin hi++; len++; @(negedge clk); end
    while (!frame) begin len++; @(negedge clk); end
    check("R2 frame_o width", hi, DIV);
    check("R2 frame period", len, FRAME);
  endtask

  task automatic t_ilim();
    wr(0, 0, 15);
    check("R8 ilim ch0 0xF", int'(ilim[3:0]), 15);
    wr(1, 0, 5);
    wr(2, 0, 10);
    check("R8 ilim all", int'(ilim), 12'hA5F);
    check("R10 ilim ch0 kept", int'(ilim[3:0]), 15);
  endtask

  task automatic t_sweep();
    for (int c = 0; c < 64; c++) begin
      int b, d;
      b = 63 - c;
      d = (c * 5 + 7) % 64;
      wr(0, c, 15); wr(1, b, 5); wr(2, d, 10);
      wait_frame();
      measure(c, b, d, $sformatf("sweep code %0d", c));
    end
  endtask

  task automatic t_edges();
    wr(0, 0, 15); wr(1, 63, 5); wr(2, 9, 10);
    wait_frame();
    measure(0, 63, 9, "R5 R6 zero/full");
  endtask

  task automatic t_midframe();
    wr(0, 20, 15); wr(1, 40, 5); wr(2, 54, 10);
    wait_frame();
    fork
      measure(20, 40, 54, "R7 old frame");
      begin
        repeat (100) @(negedge clk);
        wr(0, 62, 15); wr(1, 1, 5); wr(2, 27, 10);
      end
    join
    measure(62, 1, 27, "R7 new frame");
  endtask

  task automatic t_bad_ch();
    wr(3, 63, 3);
    check("R9 ilim unchanged", int'(ilim), 12'hA5F);
    wait_frame();
    measure(62, 1, 27, "R9 duty unchanged");
    wr(1, 7, 5);
    wait_frame();
    measure(62, 7, 27, "R10 single write");
  endtask

  initial begin
    t_reset();
    t_period();
    t_ilim();
    t_edges();
    t_sweep();
    t_midframe();
    t_bad_ch();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule